// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog timer for a system controller. A counter advances upward on ticks of a slow functional clock, optionally divided by a power-of-two prescaler. When the counter passes its all-ones value while the watchdog is running, the block emits a one-cycle reset pulse and restarts the count from a programmable load value. Software keeps the system alive by writing the trigger register with a value that differs from the previous one. Each such write restarts the count from the load value.

The watchdog cannot be started or stopped by a single stray write. Starting takes the key word 0xBBBB followed by 0x4444 in the key register. Stopping takes 0xAAAA followed by 0x5555. Every register write is posted: it is held in a shadow slot and takes effect only after three slow-clock ticks. A status register shows one pending flag for each slot while its write is in flight. Software polls that register before it issues the next write. The slow clock is modelled as a tick enable, `slow_tick`, in the bus clock domain.

Top module: `wdt_magic`

## Requirements
- R1: After reset the watchdog is disabled, the control register reads 0, all pending flags read 0, `wdt_rst` is low, and both the load register and the counter read all-ones minus DEF_MARGIN.
- R2: The register map uses these addresses: 0 control, 1 load, 2 trigger, 3 key, 4 pending status, 5 counter. The status bits are bit 0 control, bit 1 load, bit 2 trigger and bit 3 key. A write raises its pending bit from the next cycle on. The bit stays high for exactly three slow ticks. On the third tick the bit clears and the new value takes effect. Before that tick, reads return the old value.
- R3: If the key register receives 0xBBBB and then 0x4444, the watchdog becomes enabled. The counter does not advance on the tick at which the enable takes effect. It then advances by one on every later slow tick while the prescaler is off.
- R4: If the key register receives 0xAAAA and then 0x5555, the watchdog becomes disabled.
- R5: A key value that does not continue the current sequence cancels that sequence. Examples are 0xBBBB followed by any word other than 0x4444, or 0xAAAA followed by any word other than 0x5555. The enabled state does not change.
- R6: An applied trigger write reloads the counter from the load register and clears the prescaler, but only when its value differs from the last applied trigger value. That last value is 0 after reset. A write of the same value leaves the counter untouched.
- R7: While enabled, a counter step from all-ones reloads the counter from the load register. `wdt_rst` is then high for exactly the next bus clock cycle.
- R8: Control bit 5 enables the prescaler and bits 2:0 hold a value p. With the prescaler enabled, the counter advances once every 2^p slow ticks. After a reload it first advances on the 2^p-th tick.
- R9: While disabled, the counter holds its value on slow ticks. Only an applied trigger write can change it.
- R10: A write to a slot whose previous write is still pending replaces the shadow value and restarts that slot's three-tick delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable marking a slow functional clock tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The posting delay and the apply path can go wrong internally, for example by miscounting ticks or applying to the wrong slot. Either fault shows at the status and register reads on the tick it happens. A fault in the key sequencer or the enable only shows once the counter moves, or fails to move, on the following slow tick. Prescaler and wrap faults show as a counter value that is off after a handful of ticks, or as a reset pulse that is missing, late or too long. Each scenario therefore reads the counter tick by tick around every transition.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_LOAD  = 3'd1;
  localparam logic [2:0] A_TRIG  = 3'd2;
  localparam logic [2:0] A_KEY   = 3'd3;
  localparam logic [2:0] A_PEND  = 3'd4;
  localparam logic [2:0] A_COUNT = 3'd5;

  localparam int NSLOT        = 4;
  localparam int CTRL_PEN_BIT = 5;

  localparam logic [31:0] KEY_ON1  = 32'h0000_BBBB;
  localparam logic [31:0] KEY_ON2  = 32'h0000_4444;
  localparam logic [31:0] KEY_OFF1 = 32'h0000_AAAA;
  localparam logic [31:0] KEY_OFF2 = 32'h0000_5555;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_ON1  = 2'd1,
    KS_OFF1 = 2'd2
  } key_state_t;
endpackage

// File: rtl/wdt_post.sv
module wdt_post #(
  parameter int DW    = 32,
  parameter int DELAY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          pend,
  output logic          apply,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_d;
  logic [DW-1:0] data_d;

  assign apply = pend && slow_tick && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend;
    data_d = data;
    if (wr) begin
      cnt_d  = '0;
      pend_d = 1'b1;
      data_d = wdata;
    end else if (pend && slow_tick) begin
      if (cnt_q == LAST) begin
        pend_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
      data  <= '0;
    end else begin
      cnt_q <= cnt_d;
      pend  <= pend_d;
      data  <= data_d;
    end
  end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_apply,
  input  logic [DW-1:0] key_data,
  output logic          en
);
  key_state_t st_q, st_d;
  logic       en_d;

  always_comb begin
    st_d = st_q;
    en_d = en;
    if (key_apply) begin
      if (key_data == DW'(KEY_ON1)) begin
        st_d = KS_ON1;
      end else if (key_data == DW'(KEY_OFF1)) begin
        st_d = KS_OFF1;
      end else if (st_q == KS_ON1 && key_data == DW'(KEY_ON2)) begin
        st_d = KS_IDLE;
        en_d = 1'b1;
      end else if (st_q == KS_OFF1 && key_data == DW'(KEY_OFF2)) begin
        st_d = KS_IDLE;
        en_d = 1'b0;
      end else begin
        st_d = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= KS_IDLE;
      en   <= 1'b0;
    end else begin
      st_q <= st_d;
      en   <= en_d;
    end
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int          DW    = 32,
  parameter int          PTV_W = 3,
  parameter logic [DW-1:0] CNT_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             en,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  input  logic             reload,
  input  logic [DW-1:0]    load,
  output logic [DW-1:0]    count,
  output logic             wdt_rst
);
  localparam int PW = (2 ** PTV_W) - 1;

  logic [PW-1:0] pre_q, pre_d, pre_mask;
  logic [DW-1:0] cnt_d;
  logic          step, wrap;

  assign pre_mask = (PW'(1) << ptv) - PW'(1);
  assign step     = en && slow_tick && (!pre_en || (pre_q == pre_mask));

  always_comb begin
    cnt_d = count;
    pre_d = pre_q;
    wrap  = 1'b0;
    if (reload) begin
      cnt_d = load;
      pre_d = '0;
    end else if (step) begin
      pre_d = '0;
      if (count == '1) begin
        cnt_d = load;
        wrap  = 1'b1;
      end else begin
        cnt_d = count + DW'(1);
      end
    end else if (en && slow_tick && pre_en) begin
      pre_d = pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= CNT_RST;
      pre_q   <= '0;
      wdt_rst <= 1'b0;
    end else begin
      count   <= cnt_d;
      pre_q   <= pre_d;
      wdt_rst <= wrap;
    end
  end
endmodule

// File: rtl/wdt_magic.sv
module wdt_magic
  import wdt_pkg::*;
#(
  parameter int DW         = 32,
  parameter int PTV_W      = 3,
  parameter int DELAY      = 3,
  parameter int DEF_MARGIN = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        wdt_rst
);
  localparam logic [DW-1:0] LOAD_RST = {DW{1'b1}} - DW'(DEF_MARGIN);

  logic [NSLOT-1:0] pend, apply;
  logic [DW-1:0]    sdata [NSLOT];

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      wdt_post #(.DW(DW), .DELAY(DELAY)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_tick(slow_tick),
        .wr       (wr_en && (wr_addr == 3'(i))),
        .wdata    (DW'(wr_data)),
        .pend     (pend[i]),
        .apply    (apply[i]),
        .data     (sdata[i])
      );
    end
  endgenerate

  logic             pre_en_q, pre_en_d;
  logic [PTV_W-1:0] ptv_q, ptv_d;
  logic [DW-1:0]    load_q, load_d, trig_q, trig_d;
  logic             reload, en;
  logic [DW-1:0]    count;

  assign reload = apply[2] && (sdata[2] != trig_q);

  always_comb begin
    pre_en_d = pre_en_q;
    ptv_d    = ptv_q;
    load_d   = load_q;
    trig_d   = trig_q;
    if (apply[0]) begin
      pre_en_d = sdata[0][CTRL_PEN_BIT];
      ptv_d    = sdata[0][PTV_W-1:0];
    end
    if (apply[1]) load_d = sdata[1];
    if (apply[2]) trig_d = sdata[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_en_q <= 1'b0;
      ptv_q    <= '0;
      load_q   <= LOAD_RST;
      trig_q   <= '0;
    end else begin
      pre_en_q <= pre_en_d;
      ptv_q    <= ptv_d;
      load_q   <= load_d;
      trig_q   <= trig_d;
    end
  end

  wdt_keyseq #(.DW(DW)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_apply(apply[3]),
    .key_data (sdata[3]),
    .en       (en)
  );

  wdt_count #(.DW(DW), .PTV_W(PTV_W), .CNT_RST(LOAD_RST)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .en       (en),
    .pre_en   (pre_en_q),
    .ptv      (ptv_q),
    .reload   (reload),
    .load     (load_q),
    .count    (count),
    .wdt_rst  (wdt_rst)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[CTRL_PEN_BIT] = pre_en_q;
        rd_data[PTV_W-1:0]    = ptv_q;
      end
      A_LOAD:  rd_data = 32'(load_q);
      A_TRIG:  rd_data = 32'(trig_q);
      A_PEND:  rd_data = 32'(pend);
      A_COUNT: rd_data = 32'(count);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdt_magic_chk.sv
module wdt_magic_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slow_tick,
  input logic          wr_en,
  input logic          wdt_rst,
  input logic [3:0]    pend,
  input logic          en,
  input logic [DW-1:0] count
);
  AST_PEND_RISE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) != 4'b0) |-> $past(wr_en)); // R2
  AST_PEND_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend & $past(pend)) != 4'b0) |-> $past(slow_tick)); // R2
  AST_EN_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (en != $past(en)) |-> ($past(slow_tick) && $past(pend[3]))); // R3
  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(en)); // R7
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ($past(slow_tick) && ($past(en) || $past(pend[2])))); // R9
endmodule

bind wdt_magic wdt_magic_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .slow_tick(slow_tick),
  .wr_en    (wr_en),
  .wdt_rst  (wdt_rst),
  .pend     (pend),
  .en       (en),
  .count    (count)
);

// File: tb/wdt_magic_test.sv
module wdt_magic_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LOAD_RST = 32'hFFFF_FFFF - 32'd255;

  logic        clk, rst_n, slow_tick, wr_en, wdt_rst;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  int checks, errors;
  logic seen_rst;

  wdt_magic uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .wdt_rst(wdt_rst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    seen_rst = wdt_rst;
    @(negedge clk);
    if (seen_rst) check("R7 pulse one cycle", {31'b0, wdt_rst}, 32'd0);
  endtask

  task automatic post(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    repeat (3) tick();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 ctrl", v, 32'd0);
    rd(3'd1, v); check("R1 load", v, LOAD_RST);
    rd(3'd4, v); check("R1 pend", v, 32'd0);
    rd(3'd5, v); check("R1 count", v, LOAD_RST);
    check("R1 wdt_rst", {31'b0, wdt_rst}, 32'd0);
    tick(); tick();
    rd(3'd5, v); check("R9 frozen while disabled", v, LOAD_RST);
  endtask

  task automatic t_post();
    logic [31:0] v;
    wr(3'd1, 32'h1234_5678);
    rd(3'd4, v); check("R2 pend set", v, 32'h2);
    rd(3'd1, v); check("R2 old value", v, LOAD_RST);
    tick(); tick();
    rd(3'd4, v); check("R2 pend after 2 ticks", v, 32'h2);
    rd(3'd1, v); check("R2 still old", v, LOAD_RST);
    tick();
    rd(3'd4, v); check("R2 pend clear", v, 32'd0);
    rd(3'd1, v); check("R2 applied", v, 32'h1234_5678);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(3'd1, 32'h0000_AAAA_);
    tick();
    wr(3'd1, 32'h0000_0100);
    tick(); tick();
    rd(3'd4, v); check("R10 still pending", v, 32'h2);
    rd(3'd1, v); check("R10 not applied early", v, 32'h1234_5678);
    tick();
    rd(3'd1, v); check("R10 newest value", v, 32'h0000_0100);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    post(3'd2, 32'd1);
    rd(3'd5, v); check("R6 reload on new value", v, 32'h0000_0100);
    post(3'd1, 32'h0000_0300);
    post(3'd2, 32'd1);
    rd(3'd5, v); check("R6 same value ignored", v, 32'h0000_0100);
    post(3'd2, 32'd2);
    rd(3'd5, v); check("R6 reload on change", v, 32'h0000_0300);
  endtask

  task automatic t_start();
    logic [31:0] v;
    post(3'd3, 32'h0000_BBBB);
    rd(3'd5, v); check("R3 first word alone", v, 32'h0000_0300);
    post(3'd3, 32'h0000_4444);
    rd(3'd5, v); check("R3 no step on enable tick", v, 32'h0000_0300);
    tick();
    rd(3'd5, v); check("R3 counting 1", v, 32'h0000_0301);
    tick();
    rd(3'd5, v); check("R3 counting 2", v, 32'h0000_0302);
  endtask

  task automatic t_pre();
    logic [31:0] v;
    post(3'd0, 32'h0000_0022);
    rd(3'd0, v); check("R8 ctrl readback", v, 32'h0000_0022);
    post(3'd2, 32'd3);
    rd(3'd5, v); check("R8 reloaded", v, 32'h0000_0300);
    repeat (3) tick();
    rd(3'd5, v); check("R8 held for 3 ticks", v, 32'h0000_0300);
    tick();
    rd(3'd5, v); check("R8 step on 4th tick", v, 32'h0000_0301);
    repeat (4) tick();
    rd(3'd5, v); check("R8 step on 8th tick", v, 32'h0000_0302);
    post(3'd0, 32'd0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    post(3'd1, 32'hFFFF_FFFD);
    post(3'd2, 32'd4);
    rd(3'd5, v); check("R7 start", v, 32'hFFFF_FFFD);
    tick();
    check("R7 no early pulse", {31'b0, seen_rst}, 32'd0);
    tick();
    rd(3'd5, v); check("R7 at max", v, 32'hFFFF_FFFF);
    tick();
    check("R7 pulse seen", {31'b0, seen_rst}, 32'd1);
    rd(3'd5, v); check("R7 reloaded", v, 32'hFFFF_FFFD);
  endtask

  task automatic t_stop_bad();
    logic [31:0] v, c;
    post(3'd1, 32'h0000_0200);
    post(3'd2, 32'd5);
    post(3'd3, 32'h0000_AAAA);
    post(3'd3, 32'h0000_5555);
    rd(3'd5, c);
    tick(); tick();
    rd(3'd5, v); check("R4 stopped", v, c);
    post(3'd3, 32'h0000_BBBB);
    post(3'd3, 32'h0000_1234);
    post(3'd3, 32'h0000_4444);
    tick();
    rd(3'd5, v); check("R5 broken sequence ignored", v, c);
    post(3'd3, 32'h0000_BBBB);
    post(3'd3, 32'h0000_4444);
    tick();
    rd(3'd5, v); check("R3 restart after cancel", v, c + 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; seen_rst = 1'b0;
    rst_n = 1'b0; slow_tick = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_post();
    t_restart();
    t_trigger();
    t_start();
    t_pre();
    t_wrap();
    t_stop_bad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule